// File: doc/BRIEF.md
# Fault Status and Interrupt Controller

This block gathers circuit-breaker trip events from a set of power channels and keeps them in sticky status registers, one bit per channel for faults on the main output and a second bit per channel for faults on the auxiliary output. Whenever any of these bits is pending and interrupts are not masked, the block pulls an active-low interrupt line to the host processor. The analog fault detection and the serial management bus are outside the block. A bus bridge drives a simple single-cycle register port made of address, write data, write strobe and combinational read data.

The host handles events in one of two ways. In interrupt mode the line tells the host that status needs attention. In polled mode the host sets a mask bit so the line never asserts, and it reads the status registers when it chooses. In both modes a status bit is cleared by writing a 1 to its position. A bit therefore keeps its value until software has dealt with it, and software decides the earliest moment another interrupt can appear. The register port has no back-pressure: each write strobe takes effect at the next clock edge, and read data follows the address in the same cycle.

Register map, with the address width set by `ADDR_W`:
- address 0, control: bit 0 is the interrupt mask (read/write). Bit 1 is a read-only pending summary. All other bits read 0.
- address 1, main-output fault status: bit n belongs to channel n.
- address 2, auxiliary-output fault status: bit n belongs to channel n.

Top module: `fault_irq_ctrl`

## Requirements
- R1: After the asynchronous reset, both status registers read 0, the mask bit (address 0, bit 0) reads 0, and `irq_n` is 1.
- R2: A high level on `main_fault_i[n]` at a clock edge sets bit n of the main status register (address 1), and the bit is readable right after that edge.
- R3: A high level on `aux_fault_i[n]` at a clock edge sets bit n of the auxiliary status register (address 2), and it leaves the main register unchanged.
- R4: A fault sets its status bit whatever the value of the mask bit.
- R5: With the mask at 0, `irq_n` goes low at the clock edge after the one where a status bit became set. The line is registered, so it is still high right after the setting edge.
- R6: Writing 1 to address 0 bit 0 sets the mask. While the mask is 1, `irq_n` stays high even with bits pending. Clearing the mask while bits are pending brings `irq_n` low one edge later.
- R7: A write to a status register clears each bit whose write-data bit is 1 and leaves each bit whose write-data bit is 0 unchanged.
- R8: `irq_n` returns high only when no status bit in either register is pending. It rises one edge after the write that clears the last pending bit.
- R9: When a fault and a clearing write hit the same bit in the same cycle, the fault wins and the bit stays set.
- R10: A status bit stays set after its fault input drops, for as long as no clearing write reaches it.
- R11: Address 0 bit 1 reads 1 exactly when some status bit is pending, whatever the mask. Writes to this bit have no effect.
- R12: Writes to addresses above 2 change no register, and reads from those addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| main_fault_i | input | NCH | Per-channel main-output breaker trip events |
| aux_fault_i | input | NCH | Per-channel auxiliary-output breaker trip events |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_we | input | 1 | Write strobe, one write per cycle it is high |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| irq_n | output | 1 | Interrupt request to the host, active low, registered |

## Verification
The bench targets the cycle where a fault and a clearing write land on the same bit. A design that gives the clear priority would lose that event and leave the host unaware of it. It clears one register while the other still holds a pending bit, to catch a design that releases `irq_n` early. It also writes 0 bits and unmapped addresses to catch a design that clears bits it should leave alone. Mask checks confirm that status still captures while the line stays quiet, and that clearing the mask re-asserts the line for events already pending. Timing checks sample `irq_n` right after the setting edge and right after the clearing edge, so a design that drops the output register or adds one more stage would fail them.

// File: rtl/fsi_pkg.sv
package fsi_pkg;
  // Register addresses; the host driver decodes these values.
  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_MAIN = 1;
  localparam int unsigned ADDR_AUX  = 2;
  // Bit positions inside the control register.
  localparam int unsigned CTRL_MASK_BIT = 0;
  localparam int unsigned CTRL_PEND_BIT = 1;
endpackage

// File: rtl/fsi_status_bank.sv
// Sticky write-one-to-clear status bits; a set event beats a clear.
module fsi_status_bank #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] evt_i,
  input  logic [NCH-1:0] clr_i,
  output logic [NCH-1:0] stat_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          stat_o[g] <= 1'b0;
      else if (evt_i[g])   stat_o[g] <= 1'b1;
      else if (clr_i[g])   stat_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/fsi_reg_decode.sv
// Address decode for writes and read data multiplexer.
module fsi_reg_decode
  import fsi_pkg::*;
#(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  input  logic              mask_i,
  input  logic [NCH-1:0]    main_i,
  input  logic [NCH-1:0]    aux_i,
  output logic [NCH-1:0]    clr_main_o,
  output logic [NCH-1:0]    clr_aux_o,
  output logic              mask_we_o,
  output logic              mask_wd_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_MAIN = ADDR_W'(ADDR_MAIN);
  localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'(ADDR_AUX);

  logic hit_ctrl, hit_main, hit_aux;

  assign hit_ctrl = (addr_i == A_CTRL);
  assign hit_main = (addr_i == A_MAIN);
  assign hit_aux  = (addr_i == A_AUX);

  assign clr_main_o = (we_i && hit_main) ? wdata_i[NCH-1:0] : '0;
  assign clr_aux_o  = (we_i && hit_aux)  ? wdata_i[NCH-1:0] : '0;
  assign mask_we_o  = we_i && hit_ctrl;
  assign mask_wd_o  = wdata_i[CTRL_MASK_BIT];

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl) begin
      rdata_o[CTRL_MASK_BIT] = mask_i;
      rdata_o[CTRL_PEND_BIT] = (|main_i) | (|aux_i);
    end else if (hit_main) begin
      rdata_o[NCH-1:0] = main_i;
    end else if (hit_aux) begin
      rdata_o[NCH-1:0] = aux_i;
    end
  end

  if (NCH < DATA_W) begin : g_spare
    logic unused_wbits;
    assign unused_wbits = ^wdata_i[DATA_W-1:NCH];
  end
endmodule

// File: rtl/fsi_irq_gen.sv
// Mask register and registered active-low interrupt output.
module fsi_irq_gen #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mask_we_i,
  input  logic           mask_wd_i,
  input  logic [NCH-1:0] main_i,
  input  logic [NCH-1:0] aux_i,
  output logic           mask_o,
  output logic           irq_n_o
);
  logic want_irq;

  assign want_irq = ((|main_i) | (|aux_i)) & ~mask_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mask_o <= 1'b0;
    else if (mask_we_i) mask_o <= mask_wd_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_n_o <= 1'b1;
    else        irq_n_o <= ~want_irq;
  end
endmodule

// File: rtl/fault_irq_ctrl.sv
module fault_irq_ctrl #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    main_fault_i,
  input  logic [NCH-1:0]    aux_fault_i,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              reg_we,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_n
);
  logic [NCH-1:0] main_q, aux_q;
  logic [NCH-1:0] clr_main, clr_aux;
  logic           mask_we, mask_wd, mask_q;

  fsi_reg_decode #(.NCH(NCH), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .addr_i(reg_addr), .wdata_i(reg_wdata), .we_i(reg_we),
    .mask_i(mask_q), .main_i(main_q), .aux_i(aux_q),
    .clr_main_o(clr_main), .clr_aux_o(clr_aux),
    .mask_we_o(mask_we), .mask_wd_o(mask_wd), .rdata_o(reg_rdata)
  );

  fsi_status_bank #(.NCH(NCH)) u_main (
    .clk(clk), .rst_n(rst_n), .evt_i(main_fault_i), .clr_i(clr_main), .stat_o(main_q)
  );

  fsi_status_bank #(.NCH(NCH)) u_aux (
    .clk(clk), .rst_n(rst_n), .evt_i(aux_fault_i), .clr_i(clr_aux), .stat_o(aux_q)
  );

  fsi_irq_gen #(.NCH(NCH)) u_irq (
    .clk(clk), .rst_n(rst_n), .mask_we_i(mask_we), .mask_wd_i(mask_wd),
    .main_i(main_q), .aux_i(aux_q), .mask_o(mask_q), .irq_n_o(irq_n)
  );
endmodule

// File: rtl/fsi_checker.sv
module fsi_checker #(
  parameter int unsigned NCH    = 4,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    main_fault_i,
  input logic [NCH-1:0]    aux_fault_i,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_we,
  input logic [NCH-1:0]    main_q,
  input logic [NCH-1:0]    aux_q,
  input logic              mask_q,
  input logic              irq_n
);
  logic wr_main, wr_aux, pend;
  assign wr_main = reg_we && (reg_addr == ADDR_W'(fsi_pkg::ADDR_MAIN));
  assign wr_aux  = reg_we && (reg_addr == ADDR_W'(fsi_pkg::ADDR_AUX));
  assign pend    = (|main_q) | (|aux_q);

  // R2 and R9: a main fault always lands, even against a clearing write
  p_main_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (|main_fault_i) |=> ((main_q & $past(main_fault_i)) == $past(main_fault_i)));

  // R3: auxiliary fault always lands
  p_aux_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|aux_fault_i) |=> ((aux_q & $past(aux_fault_i)) == $past(aux_fault_i)));

  // R10: no write to the register means no bit of it falls
  p_main_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_main |=> ((main_q & $past(main_q)) == $past(main_q)));

  p_aux_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_aux |=> ((aux_q & $past(aux_q)) == $past(aux_q)));

  // R6: mask keeps the line released
  p_mask_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |=> irq_n);

  // R5: pending and unmasked asserts the line one edge later
  p_irq_assert_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !mask_q) |=> !irq_n);

  // R8: nothing pending releases the line one edge later
  p_irq_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !pend |=> irq_n);
endmodule

bind fault_irq_ctrl fsi_checker #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .main_fault_i(main_fault_i), .aux_fault_i(aux_fault_i),
  .reg_addr(reg_addr), .reg_we(reg_we), .main_q(main_q), .aux_q(aux_q),
  .mask_q(mask_q), .irq_n(irq_n)
);

// File: tb/sim_fault_irq_ctrl.sv
`timescale 1ns/1ps
module sim_fault_irq_ctrl;
  localparam int NCH = 4, AW = 4, DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NCH-1:0] main_fault = '0, aux_fault = '0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          we = 1'b0;
  logic [DW-1:0] rdata;
  logic          irq_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fault_irq_ctrl #(.NCH(NCH), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .main_fault_i(main_fault), .aux_fault_i(aux_fault),
    .reg_addr(addr), .reg_wdata(wdata), .reg_we(we), .reg_rdata(rdata), .irq_n(irq_n)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int d);
    addr = AW'(a); #0.5; d = int'(rdata);
  endtask

  task automatic wr(input int a, input int d);
    addr = AW'(a); wdata = DW'(d); we = 1'b1;
    step();
    we = 1'b0; wdata = '0;
  endtask

  task automatic pulse(input int m, input int x);
    main_fault = NCH'(m); aux_fault = NCH'(x);
    step();
    main_fault = '0; aux_fault = '0;
  endtask

  task automatic t_reset();
    int d;
    rd(0, d); chk(d, 0, "R1 ctrl");
    rd(1, d); chk(d, 0, "R1 main");
    rd(2, d); chk(d, 0, "R1 aux");
    chk(int'(irq_n), 1, "R1 irq_n");
  endtask

  task automatic t_main_set();
    int d;
    pulse(4'h4, 0);
    rd(1, d); chk(d, 4, "R2 main bit2");
    rd(2, d); chk(d, 0, "R3 aux untouched");
    chk(int'(irq_n), 1, "R5 irq_n still high after setting edge");
    rd(0, d); chk(d, 2, "R11 pending summary");
    step();
    chk(int'(irq_n), 0, "R5 irq_n low one edge later");
    repeat (5) step();
    rd(1, d); chk(d, 4, "R10 bit held");
  endtask

  task automatic t_clear_order();
    int d;
    pulse(4'h1, 4'h8);
    rd(2, d); chk(d, 8, "R3 aux bit3");
    rd(1, d); chk(d, 5, "R2 main bits 0,2");
    wr(1, 8'h01);
    rd(1, d); chk(d, 4, "R7 clears only ones");
    wr(1, 8'h00);
    rd(1, d); chk(d, 4, "R7 zero write no effect");
    wr(1, 8'h04);
    rd(1, d); chk(d, 0, "R7 main cleared");
    step();
    chk(int'(irq_n), 0, "R8 aux still pending");
    wr(2, 8'h08);
    chk(int'(irq_n), 0, "R8 registered release");
    rd(0, d); chk(d, 0, "R11 summary clear");
    step();
    chk(int'(irq_n), 1, "R8 released");
  endtask

  task automatic t_mask();
    int d;
    wr(0, 8'h03);
    rd(0, d); chk(d, 1, "R6 mask readback, R11 bit1 not writable");
    pulse(4'h2, 0);
    rd(1, d); chk(d, 2, "R4 set while masked");
    repeat (3) step();
    chk(int'(irq_n), 1, "R6 masked line stays high");
    wr(0, 8'h00);
    chk(int'(irq_n), 1, "R6 one edge before assert");
    step();
    chk(int'(irq_n), 0, "R6 unmask asserts pending");
    wr(1, 8'h02);
    step();
    chk(int'(irq_n), 1, "R8 released after unmask case");
  endtask

  task automatic t_collide();
    int d;
    main_fault = 4'h8; aux_fault = 4'h1;
    addr = AW'(1); wdata = 8'h08; we = 1'b1;
    step();
    we = 1'b0; main_fault = '0; aux_fault = '0;
    rd(1, d); chk(d, 8, "R9 fault beats clear");
    addr = AW'(2); wdata = 8'h01; we = 1'b1; aux_fault = 4'h1;
    step();
    we = 1'b0; aux_fault = '0;
    rd(2, d); chk(d, 1, "R9 aux fault beats clear");
  endtask

  task automatic t_unmapped();
    int d;
    wr(5, 8'hFF);
    wr(15, 8'hFF);
    rd(1, d); chk(d, 8, "R12 main unchanged");
    rd(2, d); chk(d, 1, "R12 aux unchanged");
    rd(0, d); chk(d, 2, "R12 ctrl unchanged");
    rd(5, d); chk(d, 0, "R12 unmapped read zero");
    wr(1, 8'hFF); wr(2, 8'hFF);
    step();
    chk(int'(irq_n), 1, "R8 all cleared");
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #5 rst_n = 1'b0;
    #0.1;
    t_reset();
    @(negedge clk); rst_n = 1'b1;
    step();
    t_reset();
    t_main_set();
    t_clear_order();
    t_mask();
    t_collide();
    t_unmapped();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule